// File: doc/BRIEF.md
# Key-Locked Fabric Clock Control Registers

This block is a small word-wide register file that sets up one fabric clock. A control word picks one of several source clocks and two divisors that are applied one after the other. The block then produces a one-cycle clock-enable pulse at the divided rate. Each source is presented to the block as a tick input in the system clock domain. A tick means one edge of that source.

The control word is write-protected. The block comes out of reset locked. A dedicated key written to the unlock register opens the control word for writes. A different key written to the lock register closes it again. Reads are always allowed. New divisor or source settings are held back until the current output period ends, so the enable stream never produces a shortened period.

Top module: `clkctl_regblk`

## Requirements
- R1: After reset the block is locked, the status register (offset 0x00C) reads 0x00000001, and the control register (offset 0x170) reads 0x00100A00.
- R2: While locked, a write to the control register has no effect. Its read-back value and the output pulse pattern stay as before.
- R3: A write of exactly 0x0000DF0D to offset 0x008 unlocks the block, and status bit 0 then reads 0.
- R4: A write of exactly 0x0000767B to offset 0x004 locks the block, and status bit 0 then reads 1.
- R5: A write of any other value to offset 0x004 or 0x008 leaves the lock state unchanged.
- R6: The control register has the source select in bits [5:4], the first divisor in bits [13:8] and the second divisor in bits [25:20]. All other bits read 0. Every register can be read whether the block is locked or unlocked. The lock and unlock registers read 0.
- R7: `clk_en_out` is high for one cycle in the cycle after every (D0*D1)-th tick of `src_tick[select]`. Ticks on the sources that are not selected have no effect.
- R8: A divisor field of 0 divides by 1.
- R9: A new control value applies only from the cycle after the tick that completes the current D0*D1 period. That includes a write made in the very cycle of that tick; such a write waits for the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_tick | input | NUM_SRC | One tick per edge of each source clock |
| clk_en_out | output | 1 | Divided clock-enable pulse |

## Verification
Two events can land in the same cycle: a control-register write and the tick that ends a division period. The bench counts the selected ticks in its own arithmetic model. It then issues a control write in exactly the cycle where that model expects the terminal tick. It judges the result by the pulse spacing that follows. The old period must end on schedule. The new divisors must appear only after one further full period of the old value, which is the period that was latched at that terminal tick.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 2;
  localparam int DIV_W  = 6;
  localparam int SEL_LSB = 4;
  localparam int D0_LSB  = 8;
  localparam int D1_LSB  = 20;

  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_UNLOCK = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h170;

  localparam logic [DATA_W-1:0] KEY_LOCK   = 32'h0000_767B;
  localparam logic [DATA_W-1:0] KEY_UNLOCK = 32'h0000_DF0D;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] d0;
    logic [DIV_W-1:0] d1;
  } clk_cfg_t;

  function automatic clk_cfg_t unpack_cfg(input logic [DATA_W-1:0] w);
    clk_cfg_t c;
    c.sel = w[SEL_LSB +: SEL_W];
    c.d0  = w[D0_LSB  +: DIV_W];
    c.d1  = w[D1_LSB  +: DIV_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_cfg(input clk_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[D0_LSB  +: DIV_W] = c.d0;
    w[D1_LSB  +: DIV_W] = c.d1;
    return w;
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction
endpackage

// File: rtl/clkctl_lock.sv
module clkctl_lock
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  logic hit_unlock, hit_lock;

  always_comb begin
    hit_unlock = wr_en && (addr == OFS_UNLOCK) && (wdata == KEY_UNLOCK);
    hit_lock   = wr_en && (addr == OFS_LOCK)   && (wdata == KEY_LOCK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          locked <= 1'b1;
    else if (hit_lock)   locked <= 1'b1;
    else if (hit_unlock) locked <= 1'b0;
  end
endmodule

// File: rtl/clkctl_cfg_reg.sv
module clkctl_cfg_reg
  import clkctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_WORD = 32'h0010_0A00
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              locked,
  output clk_cfg_t          cfg
);
  localparam clk_cfg_t RST_CFG = unpack_cfg(RST_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg <= RST_CFG;
    else if (wr_en && !locked && (addr == OFS_CTRL))
      cfg <= unpack_cfg(wdata);
  end
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div
  import clkctl_pkg::*;
#(
  parameter int                NUM_SRC  = 4,
  parameter logic [DATA_W-1:0] RST_WORD = 32'h0010_0A00
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  clk_cfg_t           cfg_in,
  output logic               tick_en
);
  localparam clk_cfg_t RST_CFG = unpack_cfg(RST_WORD);

  clk_cfg_t         act_q;
  logic [DIV_W-1:0] cnt0_q, cnt1_q, d0_e, d1_e;
  logic             sel_tick, wrap0, wrap1, term;

  always_comb begin
    d0_e     = eff_div(act_q.d0);
    d1_e     = eff_div(act_q.d1);
    sel_tick = (int'(act_q.sel) < NUM_SRC) ? src_tick[act_q.sel] : 1'b0;
    wrap0    = (cnt0_q == d0_e - 1'b1);
    wrap1    = (cnt1_q == d1_e - 1'b1);
    term     = sel_tick && wrap0 && wrap1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= RST_CFG;
      cnt0_q  <= '0;
      cnt1_q  <= '0;
      tick_en <= 1'b0;
    end else begin
      tick_en <= term;
      if (sel_tick) begin
        if (wrap0) begin
          cnt0_q <= '0;
          cnt1_q <= wrap1 ? '0 : cnt1_q + 1'b1;
        end else begin
          cnt0_q <= cnt0_q + 1'b1;
        end
      end
      if (term) act_q <= cfg_in;
    end
  end
endmodule

// File: rtl/clkctl_regblk.sv
module clkctl_regblk
  import clkctl_pkg::*;
#(
  parameter int                NUM_SRC  = 4,
  parameter logic [DATA_W-1:0] CTRL_RST = 32'h0010_0A00
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               clk_en_out
);
  logic             locked_w;
  clk_cfg_t         cfg_w;
  logic [DATA_W-1:0] ctrl_word;

  clkctl_lock i_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .locked(locked_w)
  );

  clkctl_cfg_reg #(.RST_WORD(CTRL_RST)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .locked(locked_w), .cfg(cfg_w)
  );

  clkctl_div #(.NUM_SRC(NUM_SRC), .RST_WORD(CTRL_RST)) i_div (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_in(cfg_w),
    .tick_en(clk_en_out)
  );

  always_comb ctrl_word = pack_cfg(cfg_w);

  always_comb begin
    case (bus_addr)
      OFS_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, locked_w};
      OFS_CTRL:   bus_rdata = ctrl_word;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk
  import clkctl_pkg::*;
#(
  parameter int NUM_SRC = 4
)(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] src_tick,
  input logic               clk_en_out,
  input logic               locked,
  input logic [DATA_W-1:0]  ctrl_word
);
  AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> locked); // R1

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_we && bus_addr == OFS_CTRL) |=> $stable(ctrl_word)); // R2

  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_UNLOCK && bus_wdata == KEY_UNLOCK) |=> !locked); // R3

  AST_LOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_LOCK && bus_wdata == KEY_LOCK) |=> locked); // R4

  AST_BAD_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ((bus_addr == OFS_UNLOCK && bus_wdata != KEY_UNLOCK) ||
                (bus_addr == OFS_LOCK && bus_wdata != KEY_LOCK))) |=> $stable(locked)); // R5

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> $past(|src_tick)); // R7
endmodule

bind clkctl_regblk clkctl_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .src_tick(src_tick), .clk_en_out(clk_en_out),
  .locked(locked_w), .ctrl_word(ctrl_word)
);

// File: tb/test_clkctl_regblk.sv
module test_clkctl_regblk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic        clk_en_out;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R7";

  // bench-side model
  bit m_locked;
  int sh_sel, sh_d0, sh_d1;
  int m_sel, m_d0, m_d1, m_cnt;
  logic [7:0] lf = 8'hA5;

  always #10 clk = ~clk;

  clkctl_regblk i_clkctl_regblk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .clk_en_out(clk_en_out)
  );

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    bus_we = 1'b0;
    bus_addr = a;
    src_tick = '0;
    #1;
    chk(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  // one clock cycle: drive at negedge, model the edge, check after it
  task automatic cyc(input bit we, input logic [11:0] a, input logic [31:0] d, input logic [3:0] t);
    bit exp;
    bus_we = we; bus_addr = a; bus_wdata = d; src_tick = t;
    exp = 1'b0;
    if (t[m_sel]) begin
      if (m_cnt + 1 == m_d0 * m_d1) begin
        exp = 1'b1;
        m_cnt = 0;
        m_sel = sh_sel; m_d0 = eff(sh_d0); m_d1 = eff(sh_d1);
      end else begin
        m_cnt++;
      end
    end
    if (we && a == 12'h170 && !m_locked) begin
      sh_sel = int'(d[5:4]); sh_d0 = int'(d[13:8]); sh_d1 = int'(d[25:20]);
    end
    if (we && a == 12'h008 && d == 32'h0000DF0D) m_locked = 1'b0;
    if (we && a == 12'h004 && d == 32'h0000767B) m_locked = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    chk(clk_en_out === exp, tag, {31'b0, clk_en_out}, {31'b0, exp});
  endtask

  function automatic logic [31:0] cw(input int sel, input int d0, input int d1);
    return (32'(d1) << 20) | (32'(d0) << 8) | (32'(sel) << 4);
  endfunction

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      cyc(1'b0, 12'h000, 32'h0, rnd ? lf[3:0] : 4'hF);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d0s[5] = '{0, 1, 2, 3, 6};
    int d1s[4] = '{0, 1, 2, 4};
    m_locked = 1'b1; sh_sel = 0; sh_d0 = 10; sh_d1 = 1;
    m_sel = 0; m_d0 = 10; m_d1 = 1; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h00C, 32'h1, "R1 status");
    rd(12'h170, 32'h00100A00, "R1 ctrl");
    tag = "R1 R7 reset divide by 10";
    run(45, 1'b0);

    // R2 locked write ignored
    tag = "R2";
    cyc(1'b1, 12'h170, cw(1, 2, 2), 4'h0);
    rd(12'h170, 32'h00100A00, "R2 readback");
    run(25, 1'b0);

    // R5 wrong keys
    cyc(1'b1, 12'h008, 32'h0000DF0E, 4'h0);
    rd(12'h00C, 32'h1, "R5 bad unlock");
    cyc(1'b1, 12'h004, 32'h0000DF0D, 4'h0);
    rd(12'h00C, 32'h1, "R5 unlock key at lock reg");

    // R3 unlock
    cyc(1'b1, 12'h008, 32'h0000DF0D, 4'h0);
    rd(12'h00C, 32'h0, "R3 unlocked");
    cyc(1'b1, 12'h004, 32'h1000767B, 4'h0);
    rd(12'h00C, 32'h0, "R5 bad lock");

    // R6 layout, reserved bits read 0
    cyc(1'b1, 12'h170, 32'hFFFFFFFF, 4'h0);
    rd(12'h170, 32'h03F03F30, "R6 field mask");
    rd(12'h004, 32'h0, "R6 lock reg read");
    rd(12'h008, 32'h0, "R6 unlock reg read");
    cyc(1'b1, 12'h170, cw(0, 2, 2), 4'h0);
    rd(12'h170, cw(0, 2, 2), "R6 readback");

    // R9 write falling in the terminal cycle
    tag = "R9";
    run(20, 1'b0);
    while (m_cnt != m_d0 * m_d1 - 1) cyc(1'b0, 12'h000, 32'h0, 4'hF);
    cyc(1'b1, 12'h170, cw(0, 3, 1), 4'hF);
    run(20, 1'b0);
    // mid-period write
    run(1, 1'b0);
    cyc(1'b1, 12'h170, cw(0, 5, 1), 4'hF);
    run(20, 1'b0);

    // R7 R8 sweep over source and divisors
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 4; j++) begin
          tag = (d0s[i] == 0 || d1s[j] == 0) ? "R8" : "R7";
          cyc(1'b1, 12'h170, cw(s, d0s[i], d1s[j]), 4'h0);
          run(100, 1'b1);
        end

    // R4 lock again, then R2 under the pulse stream
    tag = "R4";
    cyc(1'b1, 12'h004, 32'h0000767B, 4'h0);
    rd(12'h00C, 32'h1, "R4 locked");
    tag = "R2";
    cyc(1'b1, 12'h170, cw(2, 1, 1), 4'h0);
    rd(12'h170, cw(3, 6, 4), "R2 locked readback");
    run(80, 1'b1);
    finish_run();
  end
endmodule